// File: doc/BRIEF.md
# Bit-Serial Scrambler and Self-Synchronising Descrambler with Seed Selection

This block whitens the serial bit stream of a direct-sequence spread-spectrum transmitter and restores the original bits at the receiver. Both paths use a 7-bit shift register with the generator x^7 + x^4 + 1. The transmit path adds taps 7 and 4 of its register to each data bit. It feeds the result back into the register, so its state depends on the seed it was started from. The receive path shifts the received bits into its own register. After seven bits it therefore matches the transmitter, whatever seed the transmitter used.

At the start of each frame, a one-cycle strobe loads the transmit register from one of two programmable seeds. A preamble-type select picks the seed, one value for long-preamble frames and one for short-preamble frames. A single enable switches both paths between scrambling and plain pass-through.

A transmit register with the wrong contents, driven by repetitive data, can stop whitening the stream. A lockup monitor watches the transmitted bits. It raises a sticky flag when the output has repeated with period 1, 2, 4 or 6 for 32 bits in a row. The flag tells the frame logic that the stream has degenerated.

Top module: `dsss_scrambler`

## Requirements
- R1: While rst_n is low at a clock edge, both output valids, both output bits and lock_flag are 0, and both shift registers are set to all ones (7'h7F). The first transmitted bit after reset, without a frame strobe, uses that all-ones state.
- R2: A transmit bit accepted with tx_in_vld high appears on tx_out_bit one clock later, with tx_out_vld high for that single cycle. When scrambling is enabled its value is d XOR s[6] XOR s[3], where s[6] is tap 7 and s[3] is tap 4 of the register. The register then shifts left with that output entering bit 0.
- R3: frame_start loads the transmit register from seed_short when short_pre is 1 and from seed_long when it is 0. The load happens in the strobe cycle. If a bit is also valid in that cycle, that bit is scrambled with the loaded seed.
- R4: In cycles with neither tx_in_vld nor frame_start, the transmit register keeps its value, so idle gaps do not change the sequence.
- R5: With scr_en low, tx_out_bit equals the input bit and the transmit register does not advance. When scr_en returns high, scrambling resumes from the held state.
- R6: A receive bit accepted with rx_in_vld high appears on rx_out_bit one clock later as c XOR r[6] XOR r[3], with rx_out_vld high. The register r then shifts in the received bit c, so from the eighth bit of any scrambled stream the output equals the original data.
- R7: With scr_en low, rx_out_bit equals the received bit, and the receive register still shifts in every received bit.
- R8: The monitor compares each transmitted bit with the transmitted bit 1, 2, 4 and 6 positions earlier. Positions before the last frame strobe count as 0. lock_flag rises after the 32nd consecutive match at any one period and not after 31.
- R9: lock_flag stays high until the next frame_start. frame_start clears it and the monitor history in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scr_en | input | 1 | 1: scramble and descramble, 0: pass-through |
| short_pre | input | 1 | Seed select: 1 short-preamble seed, 0 long-preamble seed |
| seed_long | input | 7 | Seed for long-preamble frames |
| seed_short | input | 7 | Seed for short-preamble frames |
| frame_start | input | 1 | One-cycle strobe: load transmit seed, clear monitor |
| tx_in_bit | input | 1 | Transmit data bit |
| tx_in_vld | input | 1 | Transmit data bit valid |
| tx_out_bit | output | 1 | Scrambled transmit bit |
| tx_out_vld | output | 1 | Scrambled transmit bit valid |
| rx_in_bit | input | 1 | Received scrambled bit |
| rx_in_vld | input | 1 | Received bit valid |
| rx_out_bit | output | 1 | Descrambled bit |
| rx_out_vld | output | 1 | Descrambled bit valid |
| lock_flag | output | 1 | Sticky repetitive-output flag |

## Verification
The transmit path is swept over all 128 seed values under both preamble selections with pseudo-random data. This sweep separates a wrong seed source, tap position or feedback bit from a correct one. The strobe is also issued together with a valid bit, which catches a load that takes effect a cycle late. Runs broken by idle gaps and bypass stretches confirm that the register neither advances nor loses its state.

The receiver is fed a stream scrambled from an unrelated seed, which shows that it resynchronises after seven bits. The monitor is given all-zeros, all-ones, 10, 1100 and 111000 patterns, and a real lockup from a zero seed. A period-5 pattern must not trip the flag, and a run of exactly 31 zeros marks the threshold.

// File: rtl/dsss_scr_pkg.sv
// Package: shared widths, tap positions and lockup periods of the scrambler.
// Assumes tap positions are 1-based (tap 7 is state bit 6).
package dsss_scr_pkg;
    localparam int unsigned SCR_W      = 7;
    localparam int unsigned SCR_TAP_A  = 7;
    localparam int unsigned SCR_TAP_B  = 4;
    localparam logic [SCR_W-1:0] SCR_RESET = '1;
    localparam int unsigned LOCK_NUM   = 4;
    localparam int unsigned LOCK_PERIODS [LOCK_NUM] = '{1, 2, 4, 6};
    localparam int unsigned LOCK_HIST  = 6;
endpackage

// File: rtl/dsss_scr_tx.sv
// Transmit scrambler: adds taps A and B of its register to each data bit and
// feeds the result back. A load strobe replaces the state in the same cycle,
// so a bit valid in that cycle already uses the new seed.
// Assumes at most one bit per clock; output is registered (one cycle latency).
module dsss_scr_tx #(
    parameter int unsigned W     = 7,
    parameter int unsigned TAP_A = 7,
    parameter int unsigned TAP_B = 4,
    parameter logic [W-1:0] RST_STATE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         in_bit,
    input  logic         in_vld,
    output logic         out_bit,
    output logic         out_vld
);
    logic [W-1:0] st_q;
    logic [W-1:0] st_use;
    logic         scr_bit;
    logic         alive_q;

    // Pick the state that the current bit sees and form the scrambled bit.
    always_comb begin
        st_use  = load ? seed : st_q;
        scr_bit = in_bit ^ st_use[TAP_A-1] ^ st_use[TAP_B-1];
    end

    // Advance or load the register and register the output bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= RST_STATE;
            out_bit <= 1'b0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) out_bit <= en ? scr_bit : in_bit;
            if (in_vld && en)  st_q <= {st_use[W-2:0], scr_bit};
            else if (load)     st_q <= seed;
        end
    end

    // Marks that the previous edge was outside reset, for $past checks.
    always_ff @(posedge clk) begin
        if (!rst_n) alive_q <= 1'b0;
        else        alive_q <= 1'b1;
    end

    AST_TX_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        alive_q |-> out_vld == $past(in_vld)); // R2
    AST_TX_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        alive_q && $past(in_vld) && !$past(en) |-> out_bit == $past(in_bit)); // R5
    AST_TX_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        alive_q && !$past(in_vld) && !$past(load) |-> $stable(st_q)); // R4
    AST_TX_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        alive_q && $past(load) && !$past(in_vld) |-> st_q == $past(seed)); // R3
endmodule

// File: rtl/dsss_scr_rx.sv
// Receive descrambler: removes taps A and B of a register that holds the last
// received (scrambled) bits, so it locks to any transmitter after W bits.
// Assumes at most one bit per clock; output is registered (one cycle latency).
module dsss_scr_rx #(
    parameter int unsigned W     = 7,
    parameter int unsigned TAP_A = 7,
    parameter int unsigned TAP_B = 4,
    parameter logic [W-1:0] RST_STATE = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic in_bit,
    input  logic in_vld,
    output logic out_bit,
    output logic out_vld
);
    logic [W-1:0] st_q;
    logic         alive_q;

    // Shift in every received bit and register the descrambled bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= RST_STATE;
            out_bit <= 1'b0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_bit <= en ? (in_bit ^ st_q[TAP_A-1] ^ st_q[TAP_B-1]) : in_bit;
                st_q    <= {st_q[W-2:0], in_bit};
            end
        end
    end

    // Marks that the previous edge was outside reset, for $past checks.
    always_ff @(posedge clk) begin
        if (!rst_n) alive_q <= 1'b0;
        else        alive_q <= 1'b1;
    end

    AST_RX_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        alive_q |-> out_vld == $past(in_vld)); // R6
    AST_RX_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        alive_q && $past(in_vld) && !$past(en) |-> out_bit == $past(in_bit)); // R7
    AST_RX_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        alive_q && $past(in_vld) |-> st_q[0] == $past(in_bit)); // R7
endmodule

// File: rtl/dsss_scr_lockmon.sv
// Lockup monitor: per listed period, counts consecutive output bits equal to
// the bit that many positions earlier; a run of RUN_LEN sets a sticky flag.
// Assumes history before a clear reads as zeros; clear wins over a bit.
module dsss_scr_lockmon
    import dsss_scr_pkg::*;
#(
    parameter int unsigned RUN_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic in_bit,
    input  logic in_vld,
    output logic flag
);
    localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);

    logic [LOCK_HIST-1:0] hist_q;
    logic [LOCK_NUM-1:0]  hit;
    logic                 alive_q;

    for (genvar g = 0; g < LOCK_NUM; g++) begin : g_period
        logic [CNT_W-1:0] cnt_q;
        logic             match;

        // Compare the new bit with the bit one period back.
        always_comb begin
            match  = (in_bit == hist_q[LOCK_PERIODS[g]-1]);
            hit[g] = in_vld && match && (cnt_q == CNT_W'(RUN_LEN - 1));
        end

        // Count the current run of matches, saturating at RUN_LEN.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)  cnt_q <= '0;
            else if (in_vld) begin
                if (!match)                          cnt_q <= '0;
                else if (cnt_q != CNT_W'(RUN_LEN))   cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Keep the last LOCK_HIST output bits, newest in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) hist_q <= '0;
        else if (in_vld)     hist_q <= {hist_q[LOCK_HIST-2:0], in_bit};
    end

    // Sticky flag, set when any period reaches its run length.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) flag <= 1'b0;
        else if (|hit)       flag <= 1'b1;
    end

    // Marks that the previous edge was outside reset, for $past checks.
    always_ff @(posedge clk) begin
        if (!rst_n) alive_q <= 1'b0;
        else        alive_q <= 1'b1;
    end

    AST_MON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        alive_q && $past(clear) |-> !flag); // R9
    AST_MON_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        alive_q && $past(flag) && !$past(clear) |-> flag); // R9
    AST_MON_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        alive_q && !$past(flag) && !$past(in_vld) |-> !flag); // R8
endmodule

// File: rtl/dsss_scrambler.sv
// Top: scrambler and descrambler paths with a two-seed selector and a lockup
// monitor on the transmitted stream. Assumes frame_start is one cycle wide
// and not coincident with the output of the previous frame's last bit.
module dsss_scrambler
    import dsss_scr_pkg::*;
#(
    parameter int unsigned RUN_LEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scr_en,
    input  logic             short_pre,
    input  logic [SCR_W-1:0] seed_long,
    input  logic [SCR_W-1:0] seed_short,
    input  logic             frame_start,
    input  logic             tx_in_bit,
    input  logic             tx_in_vld,
    output logic             tx_out_bit,
    output logic             tx_out_vld,
    input  logic             rx_in_bit,
    input  logic             rx_in_vld,
    output logic             rx_out_bit,
    output logic             rx_out_vld,
    output logic             lock_flag
);
    logic [SCR_W-1:0] seed_sel;

    // Choose the seed for the preamble type of the starting frame.
    always_comb seed_sel = short_pre ? seed_short : seed_long;

    dsss_scr_tx #(
        .W(SCR_W), .TAP_A(SCR_TAP_A), .TAP_B(SCR_TAP_B), .RST_STATE(SCR_RESET)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .en(scr_en), .load(frame_start),
        .seed(seed_sel), .in_bit(tx_in_bit), .in_vld(tx_in_vld),
        .out_bit(tx_out_bit), .out_vld(tx_out_vld)
    );

    dsss_scr_rx #(
        .W(SCR_W), .TAP_A(SCR_TAP_A), .TAP_B(SCR_TAP_B), .RST_STATE(SCR_RESET)
    ) u_rx (
        .clk(clk), .rst_n(rst_n), .en(scr_en),
        .in_bit(rx_in_bit), .in_vld(rx_in_vld),
        .out_bit(rx_out_bit), .out_vld(rx_out_vld)
    );

    dsss_scr_lockmon #(
        .RUN_LEN(RUN_LEN)
    ) u_mon (
        .clk(clk), .rst_n(rst_n), .clear(frame_start),
        .in_bit(tx_out_bit), .in_vld(tx_out_vld), .flag(lock_flag)
    );
endmodule

// File: tb/dsss_scrambler_tb.sv
// Bench: seed sweep, idle/bypass runs, receiver resync and lockup patterns,
// with expected bits computed from the requirement equations.
module dsss_scrambler_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RUN = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scr_en = 1'b1;
    logic short_pre = 1'b0;
    logic [6:0] seed_long = '0;
    logic [6:0] seed_short = '0;
    logic frame_start = 1'b0;
    logic tx_in_bit = 1'b0, tx_in_vld = 1'b0;
    logic rx_in_bit = 1'b0, rx_in_vld = 1'b0;
    logic tx_out_bit, tx_out_vld, rx_out_bit, rx_out_vld, lock_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [6:0]  m_tx, m_rx;
    logic [5:0]  m_hist;
    int          m_cnt [4];
    logic        m_flag;
    logic [15:0] prng = 16'hACE1;
    int          per [4] = '{1, 2, 4, 6};

    dsss_scrambler u_dut (
        .clk(clk), .rst_n(rst_n), .scr_en(scr_en), .short_pre(short_pre),
        .seed_long(seed_long), .seed_short(seed_short), .frame_start(frame_start),
        .tx_in_bit(tx_in_bit), .tx_in_vld(tx_in_vld),
        .tx_out_bit(tx_out_bit), .tx_out_vld(tx_out_vld),
        .rx_in_bit(rx_in_bit), .rx_in_vld(rx_in_vld),
        .rx_out_bit(rx_out_bit), .rx_out_vld(rx_out_vld),
        .lock_flag(lock_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic fb(input logic [6:0] s);
        return s[6] ^ s[3];
    endfunction

    function automatic logic rnd();
        prng = {prng[14:0], prng[15] ^ prng[13] ^ prng[12] ^ prng[10]};
        return prng[0];
    endfunction

    task automatic mon_clear();
        m_hist = '0; m_flag = 1'b0;
        for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    endtask

    task automatic mon_model(input logic b);
        for (int i = 0; i < 4; i++) begin
            if (b == m_hist[per[i]-1]) begin
                if (m_cnt[i] < RUN) m_cnt[i]++;
                if (m_cnt[i] == RUN) m_flag = 1'b1;
            end else m_cnt[i] = 0;
        end
        m_hist = {m_hist[4:0], b};
    endtask

    // Send one transmit bit, optionally with the frame strobe, and check it.
    task automatic tx_send(input logic b, input bit with_start, input string req);
        logic e;
        if (with_start) begin
            @(negedge clk);
            frame_start = 1'b1;
            m_tx = short_pre ? seed_short : seed_long;
            mon_clear();
        end else @(negedge clk);
        tx_in_vld = 1'b1; tx_in_bit = b;
        if (scr_en) begin
            e = b ^ fb(m_tx);
            m_tx = {m_tx[5:0], e};
        end else e = b;
        @(negedge clk);
        tx_in_vld = 1'b0; frame_start = 1'b0;
        check(tx_out_vld === 1'b1 && tx_out_bit === e, req, int'(tx_out_bit), int'(e));
        mon_model(e);
    endtask

    task automatic tx_bit(input logic b, input string req);
        tx_send(b, 1'b0, req);
    endtask

    // Frame strobe alone, after one idle cycle that lets the monitor drain.
    task automatic start(input logic sel);
        @(negedge clk);
        @(negedge clk);
        short_pre = sel; frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        m_tx = sel ? seed_short : seed_long;
        mon_clear();
    endtask

    task automatic rx_bit(input logic b, input string req);
        logic e;
        @(negedge clk);
        rx_in_vld = 1'b1; rx_in_bit = b;
        e = scr_en ? (b ^ fb(m_rx)) : b;
        m_rx = {m_rx[5:0], b};
        @(negedge clk);
        rx_in_vld = 1'b0;
        check(rx_out_vld === 1'b1 && rx_out_bit === e, req, int'(rx_out_bit), int'(e));
    endtask

    task automatic pattern(input logic [5:0] pat, input int plen, input int n);
        for (int i = 0; i < n; i++) tx_bit(pat[plen-1-(i%plen)], "R8");
    endtask

    task automatic flag_check(input logic exp, input string req);
        repeat (3) @(negedge clk);
        check(lock_flag === exp && m_flag === exp, req, int'(lock_flag), int'(exp));
    endtask

    initial begin
        logic [6:0] ls;
        logic d, c;
        m_tx = 7'h7F; m_rx = 7'h7F; mon_clear();
        repeat (3) @(negedge clk);
        // R1: reset values
        check(tx_out_vld === 1'b0 && rx_out_vld === 1'b0, "R1", int'(tx_out_vld), 0);
        check(tx_out_bit === 1'b0 && rx_out_bit === 1'b0, "R1", int'(tx_out_bit), 0);
        check(lock_flag === 1'b0, "R1", int'(lock_flag), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) tx_bit(rnd(), "R1");

        // R3 / R2: every seed under both preamble selections
        for (int sel = 0; sel < 2; sel++) begin
            for (int s = 0; s < 128; s++) begin
                seed_long = 7'(s); seed_short = ~7'(s);
                start(sel[0]);
                tx_bit(rnd(), "R3");
                for (int k = 0; k < 9; k++) tx_bit(rnd(), "R2");
            end
        end

        // R3: strobe in the same cycle as a valid bit
        seed_long = 7'h2B; seed_short = 7'h51;
        for (int sel = 0; sel < 2; sel++) begin
            short_pre = sel[0];
            @(negedge clk);
            tx_send(rnd(), 1'b1, "R3");
            for (int k = 0; k < 8; k++) tx_bit(rnd(), "R3");
        end

        // R4: idle gaps hold the sequence
        start(1'b0);
        for (int k = 0; k < 3; k++) tx_bit(rnd(), "R4");
        repeat (6) @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            tx_bit(rnd(), "R4");
            repeat (k) @(negedge clk);
        end

        // R5: bypass passes data and holds the register
        @(negedge clk); scr_en = 1'b0;
        for (int k = 0; k < 12; k++) tx_bit(rnd(), "R5");
        @(negedge clk); scr_en = 1'b1;
        for (int k = 0; k < 12; k++) tx_bit(rnd(), "R5");

        // R6: descrambler equation from its reset state
        for (int k = 0; k < 40; k++) rx_bit(rnd(), "R6");
        // R6: resync to a stream scrambled from an unrelated seed
        ls = 7'h35;
        for (int k = 0; k < 40; k++) begin
            d = rnd();
            c = d ^ fb(ls);
            ls = {ls[5:0], c};
            rx_bit(c, "R6");
            if (k >= 7) check(rx_out_bit === d, "R6", int'(rx_out_bit), int'(d));
        end

        // R7: receive bypass keeps shifting the register
        @(negedge clk); scr_en = 1'b0;
        for (int k = 0; k < 12; k++) rx_bit(rnd(), "R7");
        @(negedge clk); scr_en = 1'b1;
        for (int k = 0; k < 12; k++) rx_bit(rnd(), "R7");

        // R8: threshold of 31 versus 32 matching zeros (bypass output)
        @(negedge clk); scr_en = 1'b0;
        start(1'b0);
        pattern(6'b000000, 1, RUN - 1);
        flag_check(1'b0, "R8");
        pattern(6'b000000, 1, 1);
        flag_check(1'b1, "R8");
        // R9: flag stays up through idle time, clears on the strobe
        repeat (10) @(negedge clk);
        check(lock_flag === 1'b1, "R9", int'(lock_flag), 1);
        start(1'b0);
        check(lock_flag === 1'b0, "R9", int'(lock_flag), 0);
        // R8: the listed repetitive patterns
        pattern(6'b000001, 1, 40); flag_check(1'b1, "R8");
        start(1'b0); pattern(6'b000010, 2, 40); flag_check(1'b1, "R8");
        start(1'b0); pattern(6'b001100, 4, 40); flag_check(1'b1, "R8");
        start(1'b0); pattern(6'b111000, 6, 40); flag_check(1'b1, "R8");
        start(1'b0); pattern(6'b011000, 5, 60); flag_check(1'b0, "R8");
        // R8: real lockup from a zero seed with zero data
        @(negedge clk); scr_en = 1'b1; seed_long = 7'h00;
        start(1'b0);
        for (int k = 0; k < 40; k++) tx_bit(1'b0, "R8");
        flag_check(1'b1, "R8");
        // R8: random data from a nonzero seed matches the model
        seed_long = 7'h5A;
        start(1'b0);
        for (int k = 0; k < 60; k++) tx_bit(rnd(), "R8");
        repeat (3) @(negedge clk);
        check(lock_flag === m_flag, "R8", int'(lock_flag), int'(m_flag));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule